// File: doc/BRIEF.md
# Non-Volatile Array Controller with Mode-Gated Program and Erase

This block controls access to a main storage array and a small user-configuration region. Both are held here as on-chip RAM arrays. A 32-bit control port reaches a handful of word registers: a ready status, a mode selector, and erase command registers. A separate data port reads and writes the arrays themselves, with per-byte lane enables. Software chooses one of three behaviours through the mode selector. It can leave the arrays read-only, enable programming, or enable erasing.

An erase command either names a page of the main array by byte address or triggers a bulk clear of the main array or of the configuration region. Every erase fills the target with all-ones, one word per clock. While the sweep runs, both ports hold off new requests. The ready status therefore always reads as ready whenever software can observe it. The page count is a parameter, so a small array can stand in for a full-size one.

Top module: `nvm_ctrl`

## Requirements
- R1: The status register at control offset 0x400 always reads with bit 0 equal to 1, and a write to it changes nothing.
- R2: The mode register at control offset 0x504 resets to 0. A write stores bits [1:0] of the data, which read back unchanged, and the upper bits read as 0. The value 0x01 selects programming, 0x02 selects erasing, and 0x00 and 0x03 leave the arrays read-only.
- R3: A data-port write changes the array only while the mode register holds 0x01. Byte-enable bit i selects bits [8i+7:8i] of the 32-bit word, and lanes whose enable is clear keep their old contents.
- R4: Data-port reads are served in every mode. Addresses 0 to PAGE_CNT*PAGE_BYTES-1 map to the main array, and CFG_BASE to CFG_BASE+CFG_BYTES-1 map to the configuration region. Any other address reads as 0 and ignores writes.
- R5: A write of a main-array byte address to offset 0x508 or to offset 0x510 erases the whole page that holds that address, with the address rounded down to a page boundary. Other pages keep their contents.
- R6: A write with bit 0 set to offset 0x50C erases the whole main array and leaves the configuration region unchanged.
- R7: A write with bit 0 set to offset 0x514 erases the whole configuration region and leaves the main array unchanged.
- R8: An erase command acts only while the mode register holds 0x02. In any other mode, and for a bulk trigger with bit 0 clear, the command is ignored and no data changes.
- R9: An erase of N words acknowledges its control write N+2 cycles after the request is raised. The data port accepts no request while the erase runs.
- R10: Each accepted request on either port is answered by exactly one ready pulse, one cycle long. Ordinary control accesses answer two cycles after the request and data accesses one cycle after it.
- R11: A page-erase address at or beyond the end of the main array is ignored, and its write is acknowledged like an ordinary register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_req | input | 1 | Control request, held until reg_ready |
| reg_we | input | 1 | Control write (1) or read (0) |
| reg_addr | input | 12 | Control byte offset, word aligned |
| reg_wdata | input | 32 | Control write data |
| reg_rdata | output | 32 | Control read data, valid with reg_ready |
| reg_ready | output | 1 | Control acknowledge pulse |
| mem_req | input | 1 | Data-port request, held until mem_ready |
| mem_we | input | 1 | Data-port write (1) or read (0) |
| mem_be | input | 4 | Byte-lane enables for writes |
| mem_addr | input | 32 | Data-port byte address |
| mem_wdata | input | 32 | Data-port write data |
| mem_rdata | output | 32 | Data-port read data, valid with mem_ready |
| mem_ready | output | 1 | Data-port acknowledge pulse |

## Verification
The bench builds the block with 64-byte pages, four pages and a 256-byte configuration region. Each array therefore holds 64 words, and a page holds 16 words. With these sizes the bench can fill and read back every word after a page erase, and so confirm that neighbouring pages survive. It can also time the 66-cycle bulk erase and the 18-cycle page erase exactly. The bench starts a data-port read one cycle into a configuration erase and checks that the stall releases it at the right cycle with erased data.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

  localparam logic [11:0] OFS_STATUS  = 12'h400;
  localparam logic [11:0] OFS_MODE    = 12'h504;
  localparam logic [11:0] OFS_PAGE_A  = 12'h508;
  localparam logic [11:0] OFS_BULK    = 12'h50C;
  localparam logic [11:0] OFS_PAGE_B  = 12'h510;
  localparam logic [11:0] OFS_CFGCLR  = 12'h514;

  localparam logic [1:0] MODE_PROG  = 2'b01;
  localparam logic [1:0] MODE_ERASE = 2'b10;

  typedef enum logic [1:0] {
    CLR_PAGE = 2'd0,
    CLR_MAIN = 2'd1,
    CLR_CFG  = 2'd2
  } clr_kind_e;

endpackage

// File: rtl/nvm_bank.sv
module nvm_bank #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  logic [31:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int b = 0; b < 4; b++) begin
          if (be[b]) store[addr][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
      rdata <= store[addr];
    end
  end

endmodule

// File: rtl/nvm_clr_seq.sv
module nvm_clr_seq
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned PAGE_WORDS = 16,
  parameter int unsigned PAGE_CNT   = 4,
  parameter int unsigned CFG_WORDS  = 64,
  parameter int unsigned AW         = 6,
  parameter int unsigned PG_W       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  clr_kind_e       kind,
  input  logic [PG_W-1:0] page,
  output logic            busy,
  output logic            bank_sel,
  output logic [AW-1:0]   waddr
);

  localparam int unsigned MAIN_WORDS = PAGE_WORDS * PAGE_CNT;
  localparam int unsigned MAX_WORDS  = (MAIN_WORDS > CFG_WORDS) ? MAIN_WORDS : CFG_WORDS;
  localparam int unsigned CNT_W      = $clog2(MAX_WORDS + 1);

  logic             busy_q, busy_d;
  logic             sel_q, sel_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    busy_d = busy_q;
    sel_d  = sel_q;
    addr_d = addr_q;
    left_d = left_q;
    if (start) begin
      busy_d = 1'b1;
      unique case (kind)
        CLR_PAGE: begin
          sel_d  = 1'b0;
          addr_d = AW'(page) * AW'(PAGE_WORDS);
          left_d = CNT_W'(PAGE_WORDS);
        end
        CLR_MAIN: begin
          sel_d  = 1'b0;
          addr_d = '0;
          left_d = CNT_W'(MAIN_WORDS);
        end
        default: begin
          sel_d  = 1'b1;
          addr_d = '0;
          left_d = CNT_W'(CFG_WORDS);
        end
      endcase
    end else if (busy_q) begin
      addr_d = addr_q + 1'b1;
      left_d = left_q - 1'b1;
      busy_d = (left_q != CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      sel_q  <= sel_d;
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign busy     = busy_q;
  assign bank_sel = sel_q;
  assign waddr    = addr_q;

  // R9: the sweep advances one word per cycle until its count runs out
  p_sweep_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && left_q > CNT_W'(1) && !start) |=> (busy_q && addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/nvm_regs.sv
module nvm_regs
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned PAGE_CNT   = 4,
  parameter int unsigned PG_W       = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            we,
  input  logic [11:0]     addr,
  input  logic [31:0]     wdata,
  input  logic            busy,
  output logic [31:0]     rdata,
  output logic            ready,
  output logic [1:0]      mode,
  output logic            clr_start,
  output clr_kind_e       clr_kind,
  output logic [PG_W-1:0] clr_page
);

  localparam int unsigned PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam logic [31:0] MAIN_BYTES = 32'(PAGE_BYTES * PAGE_CNT);

  logic        pend_q, pend_d;
  logic        ack_q, ack_d;
  logic [1:0]  mode_q, mode_d;
  logic [31:0] rdata_q, rdata_d;
  logic        accept, wr, wr_mode;
  logic [9:0]  word;
  logic        is_page, is_bulk, is_cfg;
  logic        unused_lsb;

  assign unused_lsb = ^addr[1:0];
  assign word    = addr[11:2];
  assign accept  = req && !pend_q && !ack_q && !busy;
  assign wr      = accept && we;
  assign wr_mode = wr && (word == OFS_MODE[11:2]);
  assign is_page = (word == OFS_PAGE_A[11:2]) || (word == OFS_PAGE_B[11:2]);
  assign is_bulk = (word == OFS_BULK[11:2]);
  assign is_cfg  = (word == OFS_CFGCLR[11:2]);

  always_comb begin
    clr_start = 1'b0;
    clr_kind  = CLR_PAGE;
    clr_page  = wdata[PAGE_SHIFT +: PG_W];
    if (wr && mode_q == MODE_ERASE) begin
      if (is_page && wdata < MAIN_BYTES) begin
        clr_start = 1'b1;
      end else if (is_bulk && wdata[0]) begin
        clr_start = 1'b1;
        clr_kind  = CLR_MAIN;
      end else if (is_cfg && wdata[0]) begin
        clr_start = 1'b1;
        clr_kind  = CLR_CFG;
      end
    end
  end

  always_comb begin
    mode_d  = wr_mode ? wdata[1:0] : mode_q;
    rdata_d = rdata_q;
    if (accept && !we) begin
      if (word == OFS_STATUS[11:2])    rdata_d = 32'h1;
      else if (word == OFS_MODE[11:2]) rdata_d = {30'b0, mode_q};
      else                             rdata_d = '0;
    end
    ack_d  = pend_q && !busy;
    pend_d = accept ? 1'b1 : (pend_q && busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      ack_q   <= 1'b0;
      mode_q  <= 2'b00;
      rdata_q <= '0;
    end else begin
      pend_q  <= pend_d;
      ack_q   <= ack_d;
      mode_q  <= mode_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign ready = ack_q;
  assign mode  = mode_q;

  // R10: one acknowledge pulse per control access
  p_reg_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R2: the mode only moves on a write to its own offset
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned PAGE_CNT   = 4,
  parameter int unsigned CFG_BYTES  = 256,
  parameter logic [31:0] CFG_BASE   = 32'h1000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_ready,
  input  logic        mem_req,
  input  logic        mem_we,
  input  logic [3:0]  mem_be,
  input  logic [31:0] mem_addr,
  input  logic [31:0] mem_wdata,
  output logic [31:0] mem_rdata,
  output logic        mem_ready
);

  localparam int unsigned PAGE_WORDS = PAGE_BYTES / 4;
  localparam int unsigned MAIN_WORDS = PAGE_WORDS * PAGE_CNT;
  localparam int unsigned CFG_WORDS  = CFG_BYTES / 4;
  localparam int unsigned MAX_WORDS  = (MAIN_WORDS > CFG_WORDS) ? MAIN_WORDS : CFG_WORDS;
  localparam int unsigned AW         = $clog2(MAX_WORDS);
  localparam int unsigned PG_W       = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1;
  localparam logic [31:0] MAIN_BYTES = 32'(PAGE_BYTES * PAGE_CNT);
  localparam logic [31:0] CFG_END    = CFG_BASE + 32'(CFG_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic            busy, clr_sel, clr_start;
  logic [AW-1:0]   clr_addr;
  logic [1:0]      mode;
  clr_kind_e       clr_kind;
  logic [PG_W-1:0] clr_page;

  nvm_regs #(.PAGE_BYTES(PAGE_BYTES), .PAGE_CNT(PAGE_CNT), .PG_W(PG_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata), .ready(reg_ready),
    .mode(mode), .clr_start(clr_start), .clr_kind(clr_kind), .clr_page(clr_page)
  );

  nvm_clr_seq #(.PAGE_WORDS(PAGE_WORDS), .PAGE_CNT(PAGE_CNT), .CFG_WORDS(CFG_WORDS),
                .AW(AW), .PG_W(PG_W)) u_seq (
    .clk(clk), .rst_n(rst_ni), .start(clr_start), .kind(clr_kind), .page(clr_page),
    .busy(busy), .bank_sel(clr_sel), .waddr(clr_addr)
  );

  // data-port decode
  logic          hit_main, hit_cfg, mem_acc;
  logic [31:0]   offs;
  logic [AW-1:0] widx;
  logic          ack_q, ack_d;
  logic [1:0]    rsel_q, rsel_d;
  logic          unused_offs;

  assign hit_main = mem_addr < MAIN_BYTES;
  assign hit_cfg  = (mem_addr >= CFG_BASE) && (mem_addr < CFG_END);
  assign offs     = hit_cfg ? (mem_addr - CFG_BASE) : mem_addr;
  assign widx     = offs[AW+1:2];
  assign unused_offs = ^{offs[31:AW+2], offs[1:0]};
  assign mem_acc  = mem_req && !ack_q && !busy && !clr_start;

  always_comb begin
    ack_d  = mem_acc;
    rsel_d = mem_acc ? {hit_cfg, hit_main} : rsel_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      rsel_q <= 2'b00;
    end else begin
      ack_q  <= ack_d;
      rsel_q <= rsel_d;
    end
  end

  // bank ports: the erase sweep owns them while busy
  logic          b_en    [2];
  logic          b_we    [2];
  logic [3:0]    b_be    [2];
  logic [AW-1:0] b_addr  [2];
  logic [31:0]   b_rdata [2];
  logic [31:0]   b_wdata;

  assign b_wdata = busy ? '1 : mem_wdata;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam int unsigned W  = (g == 0) ? MAIN_WORDS : CFG_WORDS;
    localparam int unsigned BW = $clog2(W);
    logic hit;
    logic unused_hi;
    assign hit = (g == 0) ? hit_main : hit_cfg;

    always_comb begin
      if (busy) begin
        b_en[g]   = (clr_sel == g[0]);
        b_we[g]   = 1'b1;
        b_be[g]   = 4'hF;
        b_addr[g] = clr_addr;
      end else begin
        b_en[g]   = mem_acc && hit;
        b_we[g]   = mem_we && (mode == MODE_PROG);
        b_be[g]   = mem_be;
        b_addr[g] = widx;
      end
    end

    if (BW < AW) begin : g_trim
      assign unused_hi = ^b_addr[g][AW-1:BW];
    end else begin : g_full
      assign unused_hi = 1'b0;
    end

    nvm_bank #(.WORDS(W), .AW(BW)) u_bank (
      .clk(clk), .en(b_en[g]), .we(b_we[g]), .be(b_be[g]),
      .addr(b_addr[g][BW-1:0]), .wdata(b_wdata), .rdata(b_rdata[g])
    );
  end

  assign mem_ready = ack_q;
  assign mem_rdata = rsel_q[0] ? b_rdata[0] : (rsel_q[1] ? b_rdata[1] : '0);

  // R9: no data-port acknowledge while an erase sweep runs
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> !mem_ready);

  // R8: a sweep only starts with the mode set to erase
  p_erase_mode_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> (mode == MODE_ERASE));

  // R10: one acknowledge pulse per data access
  p_mem_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_ready |=> !mem_ready);

endmodule

// File: tb/nvm_ctrl_test.sv
module nvm_ctrl_test;

  localparam int unsigned PB    = 64;
  localparam int unsigned PC    = 4;
  localparam int unsigned CB    = 256;
  localparam logic [31:0] CBASE = 32'h1000_1000;
  localparam int unsigned PW    = PB / 4;
  localparam int unsigned MW    = PW * PC;
  localparam int unsigned CW    = CB / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_ready;
  logic        mem_req = 1'b0, mem_we = 1'b0;
  logic [3:0]  mem_be = '0;
  logic [31:0] mem_addr = '0, mem_wdata = '0, mem_rdata;
  logic        mem_ready;

  int checks = 0;
  int errors = 0;
  longint cycles = 0;

  always #5 clk = ~clk;

  nvm_ctrl #(.PAGE_BYTES(PB), .PAGE_CNT(PC), .CFG_BYTES(CB), .CFG_BASE(CBASE)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                         output logic [31:0] q, output int cyc);
    @(negedge clk);
    reg_req = 1'b1; reg_we = w; reg_addr = a; reg_wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!reg_ready && cyc < 5000);
    q = reg_rdata;
    reg_req = 1'b0;
  endtask

  task automatic mem_acc(input logic w, input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] d, output logic [31:0] q, output int cyc);
    @(negedge clk);
    mem_req = 1'b1; mem_we = w; mem_addr = a; mem_be = be; mem_wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!mem_ready && cyc < 5000);
    q = mem_rdata;
    mem_req = 1'b0;
  endtask

  task automatic set_mode(input logic [31:0] m);
    logic [31:0] q; int c;
    reg_acc(1'b1, 12'h504, m, q, c);
  endtask

  task automatic mwr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] q; int c;
    mem_acc(1'b1, a, 4'hF, d, q, c);
  endtask

  task automatic mrd(input logic [31:0] a, output logic [31:0] q);
    int c;
    mem_acc(1'b0, a, 4'h0, 32'h0, q, c);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 | 32'(i);
  endfunction

  task automatic t_reset;
    logic [31:0] q; int c;
    chk("R10", "reg_ready after reset", {31'b0, reg_ready}, 32'h0);
    chk("R10", "mem_ready after reset", {31'b0, mem_ready}, 32'h0);
    reg_acc(1'b0, 12'h504, 0, q, c);
    chk("R2", "mode reset value", q, 32'h0);
    chk("R10", "control read latency", 32'(c), 32'd2);
    reg_acc(1'b0, 12'h400, 0, q, c);
    chk("R1", "status bit 0", {31'b0, q[0]}, 32'h1);
  endtask

  task automatic t_mode_reg;
    logic [31:0] q; int c;
    reg_acc(1'b1, 12'h504, 32'h3, q, c);
    reg_acc(1'b0, 12'h504, 0, q, c);
    chk("R2", "mode readback 3", q, 32'h3);
    reg_acc(1'b1, 12'h504, 32'hFFFF_FFF1, q, c);
    reg_acc(1'b0, 12'h504, 0, q, c);
    chk("R2", "mode upper bits dropped", q, 32'h1);
    reg_acc(1'b1, 12'h400, 32'h0, q, c);
    reg_acc(1'b0, 12'h400, 0, q, c);
    chk("R1", "status after write", {31'b0, q[0]}, 32'h1);
    set_mode(0);
  endtask

  task automatic t_erase_all;
    logic [31:0] q; int c;
    set_mode(1);
    mwr(CBASE, 32'h1234_5678);
    set_mode(2);
    reg_acc(1'b1, 12'h50C, 32'h1, q, c);
    chk("R9", "bulk erase ack latency", 32'(c), 32'(MW + 2));
    mrd(0, q);           chk("R6", "main word 0 erased", q, 32'hFFFF_FFFF);
    mrd(4 * (MW/2), q);  chk("R6", "main middle word erased", q, 32'hFFFF_FFFF);
    mrd(4 * (MW-1), q);  chk("R6", "main last word erased", q, 32'hFFFF_FFFF);
    mrd(CBASE, q);       chk("R6", "cfg word kept", q, 32'h1234_5678);
  endtask

  task automatic t_write_gate;
    logic [31:0] q; int c;
    set_mode(0);
    mwr(16, 32'hDEAD_BEEF); mrd(16, q);
    chk("R3", "write ignored in mode 0", q, 32'hFFFF_FFFF);
    set_mode(2);
    mwr(16, 32'hDEAD_BEEF); mrd(16, q);
    chk("R3", "write ignored in mode 2", q, 32'hFFFF_FFFF);
    set_mode(3);
    mwr(16, 32'hDEAD_BEEF); mrd(16, q);
    chk("R3", "write ignored in mode 3", q, 32'hFFFF_FFFF);
    set_mode(1);
    mem_acc(1'b1, 16, 4'hF, 32'hDEAD_BEEF, q, c);
    chk("R10", "data write latency", 32'(c), 32'd1);
    mrd(16, q);
    chk("R3", "word write in mode 1", q, 32'hDEAD_BEEF);
    mem_acc(1'b1, 16, 4'b0010, 32'h0000_AB00, q, c); mrd(16, q);
    chk("R3", "lane 1 byte write", q, 32'hDEAD_ABEF);
    mem_acc(1'b1, 16, 4'b1001, 32'h1122_3344, q, c); mrd(16, q);
    chk("R3", "lanes 3 and 0 write", q, 32'h11AD_AB44);
    mwr(32'h0000_8000, 32'h5555_5555); mrd(32'h0000_8000, q);
    chk("R4", "unmapped address reads 0", q, 32'h0);
    set_mode(0);
    mrd(16, q);
    chk("R4", "read served in mode 0", q, 32'h11AD_AB44);
  endtask

  task automatic t_erase_gate;
    logic [31:0] q; int c;
    set_mode(1);
    reg_acc(1'b1, 12'h50C, 32'h1, q, c);
    chk("R8", "erase in mode 1 acks like a plain write", 32'(c), 32'd2);
    mrd(16, q); chk("R8", "no erase in mode 1", q, 32'h11AD_AB44);
    set_mode(3);
    reg_acc(1'b1, 12'h514, 32'h1, q, c);
    mrd(16, q); chk("R8", "no erase in mode 3", q, 32'h11AD_AB44);
    mrd(CBASE, q); chk("R8", "cfg kept in mode 3", q, 32'h1234_5678);
    set_mode(2);
    reg_acc(1'b1, 12'h50C, 32'h2, q, c);
    mrd(16, q); chk("R8", "bulk trigger with bit 0 clear ignored", q, 32'h11AD_AB44);
  endtask

  task automatic t_page_erase;
    logic [31:0] q; int c;
    set_mode(1);
    for (int i = 0; i < int'(MW); i++) mwr(32'(4 * i), pat(i));
    set_mode(2);
    reg_acc(1'b1, 12'h508, 32'(PB + 'h14), q, c);
    chk("R9", "page erase ack latency", 32'(c), 32'(PW + 2));
    for (int i = 0; i < int'(MW); i++) begin
      mrd(32'(4 * i), q);
      chk("R5", $sformatf("word %0d after unaligned page erase", i), q,
          (i / int'(PW) == 1) ? 32'hFFFF_FFFF : pat(i));
    end
    reg_acc(1'b1, 12'h510, 32'(3 * PB), q, c);
    mrd(32'(3 * PB), q);          chk("R5", "second register erases page 3 start", q, 32'hFFFF_FFFF);
    mrd(32'(4 * PC * PW - 4), q); chk("R5", "page 3 end erased", q, 32'hFFFF_FFFF);
    mrd(32'(2 * PB + 4), q);      chk("R5", "page 2 kept", q, pat(2 * int'(PW) + 1));
    reg_acc(1'b1, 12'h508, 32'(PB * PC), q, c);
    chk("R11", "out-of-range page ack latency", 32'(c), 32'd2);
    mrd(0, q);             chk("R11", "page 0 kept", q, pat(0));
    mrd(32'(2 * PB), q);   chk("R11", "page 2 start kept", q, pat(2 * int'(PW)));
  endtask

  task automatic t_cfg_stall;
    logic [31:0] q1, q2; int c1, c2;
    set_mode(1);
    for (int i = 0; i < int'(CW); i++) mwr(CBASE + 32'(4 * i), pat(i + 256));
    mrd(CBASE + 8, q1); chk("R4", "cfg region write/read", q1, pat(258));
    set_mode(2);
    fork
      reg_acc(1'b1, 12'h514, 32'h1, q1, c1);
      begin
        @(negedge clk);
        mem_acc(1'b0, CBASE + 8, 4'h0, 32'h0, q2, c2);
      end
    join
    chk("R9", "cfg erase ack latency", 32'(c1), 32'(CW + 2));
    chk("R9", "data read held off during erase", 32'(c2), 32'(CW + 1));
    chk("R9", "stalled read returns erased data", q2, 32'hFFFF_FFFF);
    mrd(CBASE, q1);                   chk("R7", "cfg first word erased", q1, 32'hFFFF_FFFF);
    mrd(CBASE + 32'(4 * (CW-1)), q1); chk("R7", "cfg last word erased", q1, 32'hFFFF_FFFF);
    mrd(0, q1);                       chk("R7", "main word kept", q1, pat(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mode_reg();
    t_erase_all();
    t_write_gate();
    t_erase_gate();
    t_page_erase();
    t_cfg_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule